// File: doc/BRIEF.md
# Protected Dual-Oscillator Clock Selector

This block decides which of two oscillator sources feeds the system clock. It holds three control bits: an enable for each oscillator and a select bit. Software changes them through a single-cycle write port, which the register clock samples. Interlock logic filters every write. The oscillator that drives the clock, or is still being handed over, cannot be switched off. The select bit cannot point at an oscillator that the same write leaves disabled.

The hardware makes no stability check. A write may enable an oscillator and select it in the same cycle. The clock hand-off is glitch-free. The old source is stopped on its own falling edges before the new source is started on its own falling edges. A two-bit status output shows, in the register domain, which source is driving the clock.

The low-power inputs freeze the selection. Idle blocks changes to the select bit. Power-down also forces both enable outputs off and ignores every write. On reset, all three bits are loaded from a one-bit fuse input.

Top module: `osc_clock_selector`

## Requirements
- R1: At no time do both oscillators gate the output clock. The status output `src_active` is never 2'b11.
- R2: Control bit 0 enables oscillator A, bit 1 enables oscillator B and bit 2 selects the source (0 = A, 1 = B). When the hand-off has settled, `sys_clk` runs at the period of the selected oscillator, and `src_active` reads 2'b01 for A and 2'b10 for B.
- R3: A write that clears the enable of the selected source, or of a source that has not yet been seen to hand over, leaves that enable bit set. The rest of the write still takes effect.
- R4: A write that moves the select bit to a source that is disabled after that write leaves the select bit unchanged. So does any select change made while `src_active` does not yet show the currently selected source.
- R5: One write may enable an oscillator and select it. It is accepted at once, with no wait for stability.
- R6: After a select change, `src_active` shows the new source within two periods of each oscillator plus three register-clock periods.
- R7: While `idle` is high, writes to the select bit are ignored. Enable writes still apply under R3, and the active oscillator keeps running.
- R8: While `pwr_down` is high, both enable outputs are 0, every write is ignored and the output clock stops. After `pwr_down` falls, the stored bits and the enable outputs come back unchanged.
- R9: Reset loads the control bits from `fuse_sel`. Fuse 0 gives 3'b001 (A on, A selected). Fuse 1 gives 3'b110 (B on, B selected).
- R10: Every high or low phase of `sys_clk` lasts at least half the period of the faster oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Active-high reset (synchronous for the register, asynchronous for the domain synchronizers) |
| fuse_sel | input | 1 | Fuse that sets the reset defaults |
| wr_en | input | 1 | Write strobe for the control bits |
| wr_data | input | 3 | Write value: {select, enable B, enable A} |
| idle | input | 1 | Idle mode; freezes the select bit |
| pwr_down | input | 1 | Power-down mode; stops the oscillators and freezes all bits |
| osc_a_clk | input | 1 | Oscillator A clock |
| osc_b_clk | input | 1 | Oscillator B clock |
| ctl_rd | output | 3 | Stored control bits |
| osc_a_en | output | 1 | Run enable for oscillator A |
| osc_b_en | output | 1 | Run enable for oscillator B |
| sys_clk | output | 1 | Selected system clock |
| src_active | output | 2 | Source driving the clock, one bit per source (bit 0 = A) |

## Verification
The interesting collision is a select change and an enable protection decided in the same write. One value selects B, which is disabled until that write enables it, and also clears the enable of A, which is still driving the clock. The stimulus table provokes this, with the hand-off logic settled on A. The result is judged by reading the stored bits as 3'b111, meaning the select was accepted and A kept alive, and then by seeing the status move to B. Clock quality is watched throughout the run by timing every output phase and by sampling the status for both sources at once.

// File: rtl/oscsel_pkg.sv
package oscsel_pkg;

    localparam int NUM_SRC = 2;
    localparam int CTL_W   = 3;
    localparam int SRC_A   = 0;
    localparam int SRC_B   = 1;

    typedef struct packed {
        logic sel_b;
        logic en_b;
        logic en_a;
    } osc_ctl_t;

    function automatic osc_ctl_t fuse_defaults(input logic fuse_b);
        osc_ctl_t d;
        d.sel_b = fuse_b;
        d.en_b  = fuse_b;
        d.en_a  = ~fuse_b;
        return d;
    endfunction

    function automatic logic src_enabled(input osc_ctl_t c, input logic pick_b);
        return pick_b ? c.en_b : c.en_a;
    endfunction

    function automatic logic [NUM_SRC-1:0] src_onehot(input logic pick_b);
        return pick_b ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/oscsel_bit_sync.sv
module oscsel_bit_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int PIPE_W = W * STAGES;

    logic [PIPE_W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[PIPE_W-W-1:0], d};
    end

    assign q = pipe[PIPE_W-1 -: W];
endmodule

// File: rtl/oscsel_dom_gate.sv
module oscsel_dom_gate #(
    parameter int STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst,
    input  logic req,
    output logic gate
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    // Falling-edge chain: the gate only changes while this oscillator is low.
    always_ff @(negedge osc_clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], req};
    end

    assign gate = chain[LAST];
endmodule

// File: rtl/oscsel_ctrl_reg.sv
module oscsel_ctrl_reg
    import oscsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fuse_b,
    input  logic               wr_en,
    input  osc_ctl_t           wr_ctl,
    input  logic               idle,
    input  logic               pwr_down,
    input  logic [NUM_SRC-1:0] busy,
    output osc_ctl_t           ctl_q
);
    logic prot_a, prot_b;
    logic nxt_en_a, nxt_en_b, nxt_sel;
    logic tgt_en, settled, sel_frozen;

    always_comb begin
        // A source stays protected while selected, or until the other source is seen alone.
        prot_a     = ~ctl_q.sel_b | ~busy[SRC_B] | busy[SRC_A];
        prot_b     =  ctl_q.sel_b | ~busy[SRC_A] | busy[SRC_B];
        nxt_en_a   = wr_ctl.en_a | (prot_a & ctl_q.en_a);
        nxt_en_b   = wr_ctl.en_b | (prot_b & ctl_q.en_b);
        tgt_en     = wr_ctl.sel_b ? nxt_en_b : nxt_en_a;
        settled    = (busy == src_onehot(ctl_q.sel_b));
        sel_frozen = idle | pwr_down;
        nxt_sel    = (!sel_frozen && settled && tgt_en) ? wr_ctl.sel_b : ctl_q.sel_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= fuse_defaults(fuse_b);
        end else if (wr_en && !pwr_down) begin
            ctl_q.sel_b <= nxt_sel;
            ctl_q.en_b  <= nxt_en_b;
            ctl_q.en_a  <= nxt_en_a;
        end
    end

    AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (rst)
        src_enabled(ctl_q, ctl_q.sel_b)) else $error("selected source disabled"); // R4

    AST_DRIVER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (busy[SRC_A] && ctl_q.en_a) |=> ctl_q.en_a) else $error("driving A lost enable"); // R3

    AST_IDLE_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        idle |=> $stable(ctl_q.sel_b)) else $error("select moved in idle"); // R7

    AST_PD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> $stable(ctl_q)) else $error("bits moved in power-down"); // R8
endmodule

// File: rtl/osc_clock_selector.sv
module osc_clock_selector
    import oscsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fuse_sel,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    input  logic       idle,
    input  logic       pwr_down,
    input  logic       osc_a_clk,
    input  logic       osc_b_clk,
    output logic [2:0] ctl_rd,
    output logic       osc_a_en,
    output logic       osc_b_en,
    output logic       sys_clk,
    output logic [1:0] src_active
);
    osc_ctl_t           ctl_q;
    logic [NUM_SRC-1:0] osc_in, gate, req, busy;

    assign osc_in = {osc_b_clk, osc_a_clk};

    oscsel_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fuse_b   (fuse_sel),
        .wr_en    (wr_en),
        .wr_ctl   (osc_ctl_t'(wr_data)),
        .idle     (idle),
        .pwr_down (pwr_down),
        .busy     (busy),
        .ctl_q    (ctl_q)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_dom
        // Request only once the other domain has dropped its gate.
        assign req[i] = (ctl_q.sel_b == 1'(i)) && !gate[NUM_SRC-1-i];

        oscsel_dom_gate #(.STAGES(SYNC_STAGES)) u_gate (
            .osc_clk (osc_in[i]),
            .rst     (rst),
            .req     (req[i]),
            .gate    (gate[i])
        );
    end

    oscsel_bit_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_stat (
        .clk (clk),
        .rst (rst),
        .d   (gate),
        .q   (busy)
    );

    assign sys_clk    = |(osc_in & gate);
    assign osc_a_en   = ctl_q.en_a & ~pwr_down;
    assign osc_b_en   = ctl_q.en_b & ~pwr_down;
    assign ctl_rd     = ctl_q;
    assign src_active = busy;

    AST_ONE_GATE: assert property (@(posedge clk) disable iff (rst)
        !(gate[SRC_A] && gate[SRC_B])) else $error("both gates open"); // R1

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy)) else $error("status shows two sources"); // R1
endmodule

// File: tb/sim_osc_clock_selector.sv
module sim_osc_clock_selector;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_A     = 7;
    localparam int HALF_B     = 11;
    localparam int MIN_PHASE  = HALF_A;
    localparam int SETTLE     = 40;
    localparam int NVEC       = 11;

    // {wr_data, idle, expected ctl_rd, expected src_active}
    localparam logic [8:0] VEC [NVEC] = '{
        {3'b011, 1'b0, 3'b011, 2'b01},  // R2 enable B only
        {3'b111, 1'b0, 3'b111, 2'b10},  // R2 select B
        {3'b110, 1'b0, 3'b110, 2'b10},  // R3 A no longer driving, may be cleared
        {3'b100, 1'b0, 3'b110, 2'b10},  // R3 clear selected B refused
        {3'b000, 1'b0, 3'b110, 2'b10},  // R4 select disabled A refused
        {3'b011, 1'b0, 3'b011, 2'b01},  // R5 enable and select A together
        {3'b001, 1'b0, 3'b001, 2'b01},  // R3 B idle source may be cleared
        {3'b101, 1'b0, 3'b001, 2'b01},  // R4 select disabled B refused
        {3'b111, 1'b1, 3'b011, 2'b01},  // R7 idle: enables apply, select frozen
        {3'b001, 1'b1, 3'b001, 2'b01},  // R7 idle: enable clear applies
        {3'b110, 1'b0, 3'b111, 2'b10}   // R3 R5 select B and clear A in one write
    };

    logic clk = 0, rst = 1, fuse_sel = 0, wr_en = 0, idle = 0, pwr_down = 0;
    logic [2:0] wr_data = '0;
    logic osc_a_clk = 0, osc_b_clk = 0;
    logic [2:0] ctl_rd;
    logic osc_a_en, osc_b_en, sys_clk;
    logic [1:0] src_active;

    int checks = 0, fails = 0, runt_cnt = 0, overlap_cnt = 0, edge_cnt = 0;
    bit done = 0;
    time last_t = 0;

    osc_clock_selector u0 (
        .clk(clk), .rst(rst), .fuse_sel(fuse_sel), .wr_en(wr_en), .wr_data(wr_data),
        .idle(idle), .pwr_down(pwr_down), .osc_a_clk(osc_a_clk), .osc_b_clk(osc_b_clk),
        .ctl_rd(ctl_rd), .osc_a_en(osc_a_en), .osc_b_en(osc_b_en), .sys_clk(sys_clk),
        .src_active(src_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Oscillators run whole periods only while enabled.
    always begin
        if (osc_a_en === 1'b1) begin #HALF_A osc_a_clk = 1; #HALF_A osc_a_clk = 0; end
        else @(osc_a_en);
    end
    always begin
        if (osc_b_en === 1'b1) begin #HALF_B osc_b_clk = 1; #HALF_B osc_b_clk = 0; end
        else @(osc_b_en);
    end

    always @(sys_clk) begin
        edge_cnt++;
        if (!rst && last_t != 0 && ($time - last_t) < MIN_PHASE) runt_cnt++;
        last_t = $time;
    end

    always @(negedge clk) if (!rst && src_active == 2'b11) overlap_cnt++;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic write(input logic [2:0] d, input logic idl);
        @(negedge clk); wr_en = 1; wr_data = d; idle = idl;
        @(negedge clk); wr_en = 0; idle = 0;
    endtask

    task automatic period(output int p);
        time t0;
        @(posedge sys_clk); t0 = $time;
        @(posedge sys_clk); p = int'($time - t0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int p;
        repeat (4) @(negedge clk);
        rst = 0;
        chk("R9 fuse0 ctl", ctl_rd, 3'b001);
        chk("R9 fuse0 enables", {osc_b_en, osc_a_en}, 2'b01);
        settle();
        chk("R2 status A", src_active, 2'b01);
        period(p);
        chk("R2 period A", p, 2*HALF_A);

        for (int i = 0; i < NVEC; i++) begin
            write(VEC[i][8:6], VEC[i][5]);
            settle();
            chk($sformatf("R2 R3 R4 R5 R7 vec%0d ctl", i), ctl_rd, VEC[i][4:2]);
            chk($sformatf("R2 vec%0d status", i), src_active, VEC[i][1:0]);
        end
        period(p);
        chk("R2 period B", p, 2*HALF_B);

        // R6 hand-off bound, B to A then A to B
        @(negedge clk); wr_en = 1; wr_data = 3'b011;
        @(negedge clk); wr_en = 0;
        #(4*HALF_A + 4*HALF_B + 3*CLK_PERIOD);
        chk("R6 switch to A bound", src_active, 2'b01);
        settle();
        @(negedge clk); wr_en = 1; wr_data = 3'b111;
        @(negedge clk); wr_en = 0;
        #(4*HALF_A + 4*HALF_B + 3*CLK_PERIOD);
        chk("R6 switch to B bound", src_active, 2'b10);
        settle();

        // R8 power-down
        @(negedge clk); pwr_down = 1; #1;
        chk("R8 enables off", {osc_b_en, osc_a_en}, 2'b00);
        repeat (5) @(negedge clk);
        edge_cnt = 0;
        write(3'b000, 1'b0);
        write(3'b101, 1'b0);
        repeat (20) @(negedge clk);
        chk("R8 clock stopped", edge_cnt, 0);
        chk("R8 writes ignored", ctl_rd, 3'b111);
        @(negedge clk); pwr_down = 0; #1;
        chk("R8 enables restored", {osc_b_en, osc_a_en}, 2'b11);
        settle();
        chk("R8 status after exit", src_active, 2'b10);
        period(p);
        chk("R8 clock resumes", p, 2*HALF_B);

        // R9 reset during power-down with fuse 1
        @(negedge clk); pwr_down = 1; fuse_sel = 1; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R9 fuse1 ctl", ctl_rd, 3'b110);
        pwr_down = 0; #1;
        chk("R9 fuse1 enables", {osc_b_en, osc_a_en}, 2'b10);
        settle();
        chk("R9 fuse1 status", src_active, 2'b10);

        // R7 idle keeps the clock running
        @(negedge clk); idle = 1;
        period(p);
        chk("R7 idle clock runs", p, 2*HALF_B);
        @(negedge clk); idle = 0;

        chk("R10 no short phase", runt_cnt, 0);
        chk("R1 never both sources", overlap_cnt, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule